// File: doc/BRIEF.md
# Persistent Mask Merge Unit

This block is a small slice of an execution unit. It holds a 32-bit mask register and uses it to merge two 32-bit operands bit by bit. A load-mask instruction writes its operand into the mask and raises a one-shot "primed" flag, which other mask-using operations may check. A merge instruction takes each result bit from the second operand where the mask bit is 1 and from the first operand where the mask bit is 0. The merge does not look at the primed flag.

The mask keeps its value across any number of merges and across unrelated instructions. Only a load-mask instruction or the side write port changes it. An interrupt handler can use that port, and the merge honours such writes. Software can read the mask out by merging 0 with all ones, and can put it back later with a load-mask of the saved value. The result is registered and appears one cycle after the issue strobe, together with a result-valid flag.

Top module: `qmerge_unit`

## Requirements
- R1: After reset the mask is 0, the primed flag is 0, res_valid is 0 and the result is 0.
- R2: When issue_valid is 1 with opcode 2'b01 (load), the mask takes opd_a and the primed flag becomes 1 in the next cycle.
- R3: When issue_valid is 1 with opcode 2'b10 (merge), the result one cycle later is (opd_a & ~mask) | (opd_b & mask). For example, mask 0x0000FFFF, opd_a 0x11223344 and opd_b 0xAABBCCDD give 0x1122CCDD.
- R4: A merge always uses the current mask, whatever the primed flag holds, including when no load has ever run since reset.
- R5: Merges and other instructions (opcode 2'b00 or 2'b11) never change the mask.
- R6: The primed flag drops to 0 in the cycle after any valid instruction other than a load.
- R7: When side_we is 1 and no load is issued in that cycle, the mask takes side_data in the next cycle. Later merges use that value.
- R8: When a load and side_we occur in the same cycle, the load's operand wins.
- R9: res_valid is 1 exactly one cycle after each issue_valid. For a load or other instruction the result is 0.
- R10: A merge with opd_a = 0 and opd_b = all ones returns the mask. A later load of that value restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction issue strobe |
| opcode | input | 2 | 00/11 other, 01 load mask, 10 merge |
| opd_a | input | 32 | First operand (load value, merge source where mask is 0) |
| opd_b | input | 32 | Second operand (merge source where mask is 1) |
| side_we | input | 1 | Side-port write enable for the mask |
| side_data | input | 32 | Side-port mask value |
| primed | output | 1 | One-shot flag raised by a load |
| res_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 32 | Registered result |

## Verification
The mask cannot be read directly, so a wrong mask only shows up at the ports as wrong bits in the next merge result. It appears one cycle after that merge is issued, however many instructions ago the corruption happened. A flag that stays set too long or clears too early shows on the primed output in the very next cycle. The bench therefore follows every load and every side write with merge readouts, so that a corrupted mask is caught within a few cycles.

// File: rtl/qmerge_pkg.sv
package qmerge_pkg;
  typedef enum logic [1:0] {
    OP_OTHER  = 2'b00,
    OP_LOAD   = 2'b01,
    OP_MERGE  = 2'b10,
    OP_OTHER2 = 2'b11
  } qm_op_e;
endpackage

// File: rtl/qmerge_mask_reg.sv
module qmerge_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         side_we,
  input  logic [W-1:0] side_val,
  input  logic         any_issue,
  output logic [W-1:0] mask,
  output logic         primed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      primed <= 1'b0;
    end else begin
      if (load_en)      mask <= load_val;
      else if (side_we) mask <= side_val;
      if (load_en)        primed <= 1'b1;
      else if (any_issue) primed <= 1'b0;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !side_we) |=> $stable(mask)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (load_en && side_we) |=> (mask == $past(load_val))); // R8
  AST_PRIME_SET: assert property (@(posedge clk) disable iff (rst)
    load_en |=> primed); // R2
  AST_PRIME_DROP: assert property (@(posedge clk) disable iff (rst)
    (any_issue && !load_en) |=> !primed); // R6
endmodule

// File: rtl/qmerge_datapath.sv
module qmerge_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic         is_merge,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] mask,
  output logic         vld,
  output logic [W-1:0] res
);
  logic [W-1:0] mix;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mix[i] = mask[i] ? b[i] : a[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      res <= '0;
    end else begin
      vld <= issue;
      res <= (issue && is_merge) ? mix : '0;
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    issue |=> vld); // R9
  AST_MERGE_BITS: assert property (@(posedge clk) disable iff (rst)
    (issue && is_merge) |=> (res == (($past(a) & ~$past(mask)) | ($past(b) & $past(mask))))); // R3
endmodule

// File: rtl/qmerge_unit.sv
module qmerge_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue_valid,
  input  logic [1:0]   opcode,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         side_we,
  input  logic [W-1:0] side_data,
  output logic         primed,
  output logic         res_valid,
  output logic [W-1:0] result
);
  import qmerge_pkg::*;

  logic         is_load, is_merge;
  logic [W-1:0] mask;

  assign is_load  = issue_valid && (qm_op_e'(opcode) == OP_LOAD);
  assign is_merge = (qm_op_e'(opcode) == OP_MERGE);

  qmerge_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .load_en(is_load), .load_val(opd_a),
    .side_we(side_we), .side_val(side_data), .any_issue(issue_valid),
    .mask(mask), .primed(primed)
  );

  qmerge_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .issue(issue_valid), .is_merge(is_merge),
    .a(opd_a), .b(opd_b), .mask(mask), .vld(res_valid), .res(result)
  );

  AST_NOISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!res_valid && result == '0)); // R9
endmodule

// File: tb/sim_qmerge_unit.sv
module sim_qmerge_unit;
  logic clk = 0, rst = 1;
  logic issue_valid = 0, side_we = 0;
  logic [1:0] opcode = 0;
  logic [31:0] opd_a = 0, opd_b = 0, side_data = 0;
  logic primed, res_valid;
  logic [31:0] result;
  int checks = 0, fails = 0;
  logic [31:0] mdl;

  always #2.5 clk = ~clk;

  qmerge_unit u0 (.clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
    .opd_a(opd_a), .opd_b(opd_b), .side_we(side_we), .side_data(side_data),
    .primed(primed), .res_valid(res_valid), .result(result));

  function automatic logic [31:0] merge_f(logic [31:0] a, logic [31:0] b, logic [31:0] m);
    return (a & ~m) | (b & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, sample after the edge
  task automatic step(logic v, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                      logic we, logic [31:0] sd);
    @(negedge clk);
    issue_valid = v; opcode = op; opd_a = a; opd_b = b; side_we = we; side_data = sd;
    @(negedge clk);
    issue_valid = 0; side_we = 0;
  endtask

  task automatic readout(string req, logic [31:0] exp);
    step(1, 2'b10, 32'h0, 32'hFFFF_FFFF, 0, 0);
    chk(req, result, exp);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 primed", {31'b0, primed}, 0);
    chk("R1 valid", {31'b0, res_valid}, 0);
    chk("R1 result", result, 0);
    // R4: merge before any load uses mask 0
    step(1, 2'b10, 32'h1234_5678, 32'hFFFF_0000, 0, 0);
    chk("R4 merge with reset mask", result, 32'h1234_5678);
    chk("R9 valid", {31'b0, res_valid}, 1);
    // R2
    step(1, 2'b01, 32'h0000_FFFF, 0, 0, 0);
    chk("R2 primed", {31'b0, primed}, 1);
    chk("R9 load result", result, 0);
    // R3 example, also clears primed (R6)
    step(1, 2'b10, 32'h1122_3344, 32'hAABB_CCDD, 0, 0);
    chk("R3 example", result, 32'h1122_CCDD);
    chk("R6 primed drop", {31'b0, primed}, 0);
    // R5: other ops interleaved
    step(1, 2'b00, 32'hDEAD_BEEF, 0, 0, 0);
    chk("R9 other result", result, 0);
    step(0, 2'b01, 32'hDEAD_BEEF, 0, 0, 0);
    chk("R9 no issue no valid", {31'b0, res_valid}, 0);
    step(1, 2'b11, 32'h1, 0, 0, 0);
    step(1, 2'b10, 32'h5566_7788, 32'h99EE_00FF, 0, 0);
    chk("R5 mask persists", result, 32'h5566_00FF);
    // R6 via other opcode
    step(1, 2'b01, 32'hF0F0_F0F0, 0, 0, 0);
    step(1, 2'b11, 0, 0, 0, 0);
    chk("R6 other clears primed", {31'b0, primed}, 0);
    // R7 side write
    step(0, 2'b00, 0, 0, 1, 32'h0F0F_0000);
    readout("R7 side write", 32'h0F0F_0000);
    // R8 collision
    step(1, 2'b01, 32'hAAAA_5555, 0, 1, 32'h1111_1111);
    readout("R8 load wins", 32'hAAAA_5555);
    // R10 save/restore
    step(1, 2'b01, 32'hC3C3_3C3C, 0, 0, 0);
    readout("R10 save", 32'hC3C3_3C3C);
    mdl = result;
    step(0, 2'b00, 0, 0, 1, 32'h0);
    step(1, 2'b01, mdl, 0, 0, 0);
    readout("R10 restore", 32'hC3C3_3C3C);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op; logic v, we; logic [31:0] a, b, sd, expm;
      v = $urandom_range(0, 3) != 0; op = 2'($urandom); we = $urandom_range(0, 5) == 0;
      a = $urandom; b = $urandom; sd = $urandom;
      expm = merge_f(a, b, mdl);
      step(v, op, a, b, we, sd);
      chk("R9 random valid", {31'b0, res_valid}, {31'b0, v});
      chk("R3 random result", result, (v && op == 2'b10) ? expm : 32'h0);
      if (v) chk("R2 R6 random primed", {31'b0, primed}, {31'b0, op == 2'b01});
      if (v && op == 2'b01) mdl = a; else if (we) mdl = sd;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule